// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a small processor built around one 8-bit accumulator. It holds a 256-byte RAM, a program counter, an instruction register, the accumulator and a zero flag. A control sequencer steps each instruction through separate fetch, decode, execute and writeback states. Every instruction names a memory operand, so the core loads, adds and stores bytes in RAM directly.

While reset is held, a loader port fills the RAM with a program and its data. When reset is released, execution starts at address 0x00 and runs until a halt. After that the accumulator, the zero flag and the RAM contents stay frozen until the next reset.

A combinational peek port lets the surrounding logic read any RAM byte, so results written by the program can be inspected. The operand byte is used directly as a RAM address, so the address width must not exceed the data width.

Top module: `accum_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `halted` is 0, `accOut` is 0x00 and `zeroFlag` is 0.
- R2: A loader write (`loadEn` high at a clock edge) stores `loadData` at `loadAddr` only while `rstN` is low. With `rstN` high, `loadEn` leaves the RAM unchanged.
- R3: Opcode 0x01 (load) copies the RAM byte at the operand address into the accumulator.
- R4: Opcode 0x02 (add) replaces the accumulator with the accumulator plus the RAM byte at the operand address, modulo 256.
- R5: Opcode 0x03 (store) writes the accumulator into RAM at the operand address and leaves the accumulator unchanged.
- R6: After a load or an add, `zeroFlag` is 1 exactly when the new accumulator value is 0x00. A store leaves the flag as it was.
- R7: Opcode 0xFF (halt) raises `halted`. From then on the accumulator, the flag and the RAM do not change until reset.
- R8: Any opcode other than 0x01, 0x02, 0x03 or 0xFF acts as a halt.
- R9: An instruction is two bytes, opcode first and operand address second. Execution begins at 0x00, and the program counter moves forward by 2 after each completed instruction.
- R10: Each load, add or store takes 5 clock cycles. A halt asserts `halted` 3 cycles after its fetch starts. A program of N non-halt instructions followed by a halt therefore raises `halted` after 5N+3 rising edges, counted from the first edge with `rstN` high.
- R11: `peekData` shows the RAM byte at `peekAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; loader writes only while low |
| loadEn | input | 1 | Loader write strobe |
| loadAddr | input | 8 | Loader write address |
| loadData | input | 8 | Loader write data |
| peekAddr | input | 8 | RAM inspection address |
| peekData | output | 8 | RAM byte at peekAddr |
| accOut | output | 8 | Accumulator value |
| zeroFlag | output | 1 | Zero result of the last load or add |
| halted | output | 1 | Core has stopped |

## Verification
Two conditions are hard to reach from the ports. The first is a halt caused by an opcode outside the defined set, partway through a program. The second is a loader strobe that arrives after the core has stopped. The bench builds a program whose second instruction holds an undefined opcode and places a real store after it. It then checks that the store never happens and that `halted` rises at the cycle the timing rule predicts. After a normal halt, the bench drives a loader write with reset released and reads the target byte back through the peek port. Separate programs drive the zero flag high and then run a store, and also run a four-deep add chain that wraps past 255.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h02;
  localparam logic [7:0] OPC_STORE = 8'h03;
  localparam logic [7:0] OPC_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH_OP,
    ST_FETCH_ADDR,
    ST_DECODE,
    ST_EXEC_MEM,
    ST_WRITEBACK,
    ST_HALTED
  } state_e;

  typedef enum logic [1:0] {
    SEL_PC,
    SEL_PC_NEXT,
    SEL_OPER
  } addrSel_e;

  typedef struct packed {
    addrSel_e addrSel;  // RAM read address source
    logic     capOp;    // capture opcode byte into instruction register
    logic     capAddr;  // capture operand byte into instruction register
    logic     accWr;    // write ALU result into accumulator
    logic     aluAdd;   // ALU adds (else passes memory byte)
    logic     memWr;    // write accumulator into RAM at operand
    logic     pcStep;   // advance program counter by one instruction
  } strobes_t;

endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] irOp,
  output strobes_t          stb,
  output logic              halted
);

  state_e state, stateNext;
  logic   isLoad, isAdd, isStore, isKnown;

  assign isLoad  = (irOp == DATA_W'(OPC_LOAD));
  assign isAdd   = (irOp == DATA_W'(OPC_ADD));
  assign isStore = (irOp == DATA_W'(OPC_STORE));
  assign isKnown = isLoad | isAdd | isStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH_OP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    stb.addrSel = SEL_PC;
    unique case (state)
      ST_FETCH_OP: begin
        stb.addrSel = SEL_PC;
        stateNext   = ST_FETCH_ADDR;
      end
      ST_FETCH_ADDR: begin
        stb.capOp   = 1'b1;
        stb.addrSel = SEL_PC_NEXT;
        stateNext   = ST_DECODE;
      end
      ST_DECODE: begin
        stb.capAddr = 1'b1;
        stateNext   = isKnown ? ST_EXEC_MEM : ST_HALTED;
      end
      ST_EXEC_MEM: begin
        stb.addrSel = SEL_OPER;
        stateNext   = ST_WRITEBACK;
      end
      ST_WRITEBACK: begin
        stb.accWr  = isLoad | isAdd;
        stb.aluAdd = isAdd;
        stb.memWr  = isStore;
        stb.pcStep = 1'b1;
        stateNext  = ST_FETCH_OP;
      end
      ST_HALTED: stateNext = ST_HALTED;
      default:   stateNext = ST_HALTED;
    endcase
  end

  assign halted = (state == ST_HALTED);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_bad_op_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECODE && !isKnown) |=> halted);

  p_fetch_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH_OP) |=> (state == ST_FETCH_ADDR));

  p_store_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.memWr && stb.accWr));

endmodule

// File: rtl/accum_dpath.sv
module accum_dpath
  import accum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] irOp,
  output logic [DATA_W-1:0] acc,
  output logic              zero
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] rdAddr, pc, irAddr;
  logic [DATA_W-1:0] aluOut;

  // read address selection
  always_comb begin
    unique case (stb.addrSel)
      SEL_PC:      rdAddr = pc;
      SEL_PC_NEXT: rdAddr = pc + ADDR_W'(1);
      SEL_OPER:    rdAddr = irAddr;
      default:     rdAddr = pc;
    endcase
  end

  // RAM: loader port during reset, store port during run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (loadEn) mem[loadAddr] <= loadData;
    end else if (stb.memWr) begin
      mem[irAddr] <= acc;
    end
    rdData <= mem[rdAddr];
  end

  assign peekData = mem[peekAddr];

  // ALU: pass-through for load, modular add for add
  assign aluOut = stb.aluAdd ? (acc + rdData) : rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      irOp   <= '0;
      irAddr <= '0;
      acc    <= '0;
      zero   <= 1'b0;
    end else begin
      if (stb.capOp)   irOp   <= rdData;
      if (stb.capAddr) irAddr <= rdData[ADDR_W-1:0];
      if (stb.accWr) begin
        acc  <= aluOut;
        zero <= (aluOut == '0);
      end
      if (stb.pcStep) pc <= pc + PC_STEP;
    end
  end

  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcStep |=> (pc == $past(pc) + PC_STEP));

  p_zero_track_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.accWr |=> (zero == (acc == '0)));

  p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWr |=> ($stable(acc) && $stable(zero)));

  p_idle_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.accWr |=> $stable(acc));

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [DATA_W-1:0] accOut,
  output logic              zeroFlag,
  output logic              halted
);

  strobes_t          stb;
  logic [DATA_W-1:0] irOp;

  accum_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .irOp   (irOp),
    .stb    (stb),
    .halted (halted)
  );

  accum_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .peekAddr (peekAddr),
    .peekData (peekData),
    .irOp     (irOp),
    .acc      (accOut),
    .zero     (zeroFlag)
  );

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> ($stable(accOut) && $stable(zeroFlag) && halted));

endmodule

// File: tb/accum_core_tb.sv
module accum_core_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [7:0] peekAddr = '0;
  logic [7:0] peekData;
  logic [7:0] accOut;
  logic       zeroFlag;
  logic       halted;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  accum_core u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .peekAddr(peekAddr), .peekData(peekData),
    .accOut(accOut), .zeroFlag(zeroFlag), .halted(halted)
  );

  // operand a, operand b, expected sum (mod 256)
  localparam logic [7:0] VEC [7][3] = '{
    '{8'h12, 8'h34, 8'h46},
    '{8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'h01, 8'h00},
    '{8'h80, 8'h80, 8'h00},
    '{8'h7F, 8'h01, 8'h80},
    '{8'hA5, 8'h0F, 8'hB4},
    '{8'h01, 8'hFE, 8'hFF}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic enterReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    peekAddr = a;
    #1;
    d = peekData;
  endtask

  task automatic runCore(output int cyc);
    rstN = 1'b1;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] rb;

    // R1: reset state, and first cycle after release
    enterReset();
    chk("R1 halted in reset", halted, 0);
    chk("R1 acc in reset", accOut, 0);
    chk("R1 zero in reset", zeroFlag, 0);
    poke(8'h00, 8'hFF);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 halted after release", halted, 0);
    chk("R1 acc after release", accOut, 0);

    // table: LOAD 80, ADD 81, STORE 82, HALT
    for (int i = 0; i < 7; i++) begin
      enterReset();
      poke(8'h00, 8'h01); poke(8'h01, 8'h80);
      poke(8'h02, 8'h02); poke(8'h03, 8'h81);
      poke(8'h04, 8'h03); poke(8'h05, 8'h82);
      poke(8'h06, 8'hFF); poke(8'h07, 8'h00);
      poke(8'h80, VEC[i][0]); poke(8'h81, VEC[i][1]); poke(8'h82, 8'hEE);
      runCore(cyc);
      chk("R3 R4 acc sum", accOut, VEC[i][2]);
      chk("R6 zero flag", zeroFlag, (VEC[i][2] == 8'h00) ? 1 : 0);
      peek(8'h82, rb);
      chk("R5 stored byte", rb, VEC[i][2]);
      chk("R10 cycles to halt", cyc, 18);
      chk("R7 halted", halted, 1);
    end

    // R11: program byte visible on peek
    peek(8'h00, rb);
    chk("R11 peek opcode byte", rb, 8'h01);

    // R2: loader with reset released is ignored
    loadEn = 1'b1; loadAddr = 8'h82; loadData = 8'h33;
    @(negedge clk);
    @(negedge clk);
    loadEn = 1'b0;
    peek(8'h82, rb);
    chk("R2 loader ignored when running", rb, 8'hFF);

    // R7: frozen after halt
    repeat (20) @(negedge clk);
    chk("R7 acc frozen", accOut, 8'hFF);
    chk("R7 still halted", halted, 1);
    peek(8'h82, rb);
    chk("R7 ram frozen", rb, 8'hFF);

    // R8: undefined opcode halts before the following store
    enterReset();
    poke(8'h00, 8'h01); poke(8'h01, 8'h80);
    poke(8'h02, 8'h42); poke(8'h03, 8'h82);
    poke(8'h04, 8'h03); poke(8'h05, 8'h82);
    poke(8'h06, 8'hFF);
    poke(8'h80, 8'h09); poke(8'h82, 8'h5A);
    runCore(cyc);
    chk("R8 halted on bad opcode", halted, 1);
    chk("R8 cycles", cyc, 8);
    chk("R8 acc", accOut, 8'h09);
    peek(8'h82, rb);
    chk("R8 store skipped", rb, 8'h5A);

    // R6: load of zero sets flag, store leaves it
    enterReset();
    poke(8'h00, 8'h01); poke(8'h01, 8'h80);
    poke(8'h02, 8'h03); poke(8'h03, 8'h82);
    poke(8'h04, 8'hFF);
    poke(8'h80, 8'h00); poke(8'h82, 8'h77);
    runCore(cyc);
    chk("R6 zero kept over store", zeroFlag, 1);
    chk("R10 cycles two-instr", cyc, 13);
    peek(8'h82, rb);
    chk("R5 stored zero", rb, 8'h00);

    // R9: longer chain, pc walks by 2, add wraps
    enterReset();
    poke(8'h00, 8'h01); poke(8'h01, 8'h90);
    poke(8'h02, 8'h02); poke(8'h03, 8'h91);
    poke(8'h04, 8'h02); poke(8'h05, 8'h92);
    poke(8'h06, 8'h02); poke(8'h07, 8'h93);
    poke(8'h08, 8'h03); poke(8'h09, 8'h94);
    poke(8'h0A, 8'h03); poke(8'h0B, 8'h95);
    poke(8'h0C, 8'hFF);
    poke(8'h90, 8'h40); poke(8'h91, 8'h50);
    poke(8'h92, 8'h60); poke(8'h93, 8'h70);
    runCore(cyc);
    chk("R9 R4 chain acc", accOut, 8'h60);
    chk("R9 cycles six-instr", cyc, 33);
    peek(8'h94, rb);
    chk("R9 first store", rb, 8'h60);
    peek(8'h95, rb);
    chk("R9 second store", rb, 8'h60);
    chk("R6 nonzero clears", zeroFlag, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule